// File: doc/BRIEF.md
# Event Counter Unit with Overflow Interrupt

This block counts hardware events for software profiling. It has a small bank of general counters and three fixed-purpose counters. The fixed counters count retired instructions, unhalted core clock cycles and unhalted bus clock cycles. The event sources reach the block as one strobe per source per cycle. A privilege input reports whether the core is running user or kernel code.

Software reaches the block through a single-cycle register port. One global control word enables each counter. A packed fixed-counter control word selects the privilege levels at which each fixed counter counts, and whether that counter may raise an interrupt. When a counter wraps, it sets a flag in a status word. Software clears these flags by writing a mask to an acknowledge address. The top bit of the status word is not an overflow flag. It reports that the control word has changed.

A build option models a core variant in which acknowledge writes take effect only while some global enable is set.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: The fixed control word holds one 4-bit field per fixed counter i, at bits 4i+3..4i. Bit 0 of a field allows counting when `priv_user`=0 (kernel). Bit 1 allows counting when `priv_user`=1 (user). Bit 3 enables that counter's interrupt. Bit 2 is stored and has no effect. The word reads back as written in bits 11:0.
- R3: Fixed counter 0 counts `ev_inst`, fixed counter 1 counts `ev_core_clk` and fixed counter 2 counts `ev_bus_clk`. Fixed counter i also needs global control bit 32+i. General counter j counts `ev_gen[j]` when global control bit j is set, at any privilege level. Each qualifying cycle adds exactly one, visible on the next clock.
- R4: When the global control word is zero, no counter advances. Only bits NUM_GP-1..0 and 34..32 of the control word are stored. All other bits read as zero.
- R5: A counter that advances from all ones wraps to zero and sets its status bit. That status bit sits at the same position as the counter's global enable bit.
- R6: Status bit 63 is set whenever a control write changes the stored control value. This bit never drives `irq`.
- R7: A write to the acknowledge address clears each status bit that is 1 in the written data. If an overflow occurs in the same cycle, its status bit stays set.
- R8: When ACK_GATED=1, an acknowledge write issued while the stored control word is zero leaves the status word unchanged.
- R9: `irq` is high while a general counter's status bit is set, or while a fixed counter's status bit is set and that counter's field bit 3 is set. It stays high until the bit is acknowledged.
- R10: Counters are CNT_W (48) bits wide. A write loads the low CNT_W data bits. Upper read bits are zero.
- R11: Register addresses are: 0 control, 1 status, 2 acknowledge, 3 fixed control, 4 to 6 fixed counters 0 to 2, and 8+j general counter j. The status word cannot be written, and the acknowledge address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr, combinational |
| ev_inst | input | 1 | Retired-instruction strobe |
| ev_core_clk | input | 1 | Unhalted core clock strobe |
| ev_bus_clk | input | 1 | Unhalted bus clock strobe |
| ev_gen | input | NUM_GP | General event strobes |
| priv_user | input | 1 | 1 = user level, 0 = kernel level |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions assume that a register write lasts one cycle, with address and data stable at the clock edge. They also assume the acknowledge address is never written in the same cycle as the control word, so status bit 63 cannot be raised and cleared together. The bench drives every register access from its own task, one access per cycle, with all event strobes low. It raises the strobes only during separate counting windows with no writes. Every new overflow therefore comes from a known number of strobed cycles.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
   localparam int FIX_NUM  = 3;
   localparam int FIX_BASE = 32;
   localparam int FLAG_BIT = 63;
   localparam int DATA_W   = 64;
   localparam int ADDR_W   = 4;
   localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
   localparam logic [ADDR_W-1:0] A_STAT = 4'd1;
   localparam logic [ADDR_W-1:0] A_ACK  = 4'd2;
   localparam logic [ADDR_W-1:0] A_FCTL = 4'd3;
   localparam int A_FIX0 = 4;
   localparam int A_GP0  = 8;
endpackage

// File: rtl/pmu_cnt.sv
`timescale 1ns/1ps
module pmu_cnt #(
   parameter int W = 48
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);
   // a software load takes priority over counting
   assign wrap_o = inc_i & ~wr_i & (&cnt_o);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_o <= '0;
      else if (wr_i)  cnt_o <= wdata_i;
      else if (inc_i) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/pmu_stat.sv
`timescale 1ns/1ps
module pmu_stat #(
   parameter int          DW        = 64,
   parameter logic [63:0] VALID     = '1,
   parameter bit          ACK_GATED = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] set_i,
   input  logic          ack_i,
   input  logic [DW-1:0] ack_data_i,
   input  logic          ctrl_live_i,
   output logic [DW-1:0] stat_o
);
   logic          ack_ok;
   logic [DW-1:0] clr;

   assign ack_ok = ack_i & (ctrl_live_i | ~ACK_GATED);
   assign clr    = ack_ok ? ack_data_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_o <= '0;
      else        stat_o <= ((stat_o & ~clr) | set_i) & VALID[DW-1:0];
   end
endmodule

// File: rtl/perf_counter_unit.sv
`timescale 1ns/1ps
module perf_counter_unit
   import pmu_pkg::*;
#(
   parameter int NUM_GP    = 2,
   parameter int CNT_W     = 48,
   parameter bit ACK_GATED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [3:0]        reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              ev_inst,
   input  logic              ev_core_clk,
   input  logic              ev_bus_clk,
   input  logic [NUM_GP-1:0] ev_gen,
   input  logic              priv_user,
   output logic              irq
);
   localparam logic [63:0] GP_MASK   = (64'd1 << NUM_GP) - 64'd1;
   localparam logic [63:0] CTRL_MASK = GP_MASK | (64'h7 << FIX_BASE);
   localparam logic [63:0] STAT_MASK = CTRL_MASK | (64'd1 << FLAG_BIT);
   localparam int          FCTL_W    = 4 * FIX_NUM;

   generate
      if (NUM_GP < 2 || NUM_GP > 4) begin : g_bad_gp
         $error("NUM_GP must lie in 2..4");
      end
      if (CNT_W < 8 || CNT_W > 63) begin : g_bad_w
         $error("CNT_W must lie in 8..63");
      end
   endgenerate

   logic [63:0]        gctrl_q;
   logic [FCTL_W-1:0]  fctl_q;
   logic [63:0]        stat_q;
   logic [63:0]        set_vec;
   logic               wr_ctrl, flag_set;
   logic [FIX_NUM-1:0] fix_ev, fix_wrap, fix_irq_en;
   logic [NUM_GP-1:0]  gp_wrap;
   logic [CNT_W-1:0]   fix_cnt [FIX_NUM];
   logic [CNT_W-1:0]   gp_cnt  [NUM_GP];

   assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
   assign flag_set = wr_ctrl && ((reg_wdata & CTRL_MASK) != gctrl_q);
   assign fix_ev   = {ev_bus_clk, ev_core_clk, ev_inst};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gctrl_q <= '0;
         fctl_q  <= '0;
      end else if (reg_wr) begin
         if (reg_addr == A_CTRL) gctrl_q <= reg_wdata & CTRL_MASK;
         if (reg_addr == A_FCTL) fctl_q  <= reg_wdata[FCTL_W-1:0];
      end
   end

   generate
      for (genvar i = 0; i < FIX_NUM; i++) begin : g_fix
         logic priv_ok, inc, wr;
         assign priv_ok = priv_user ? fctl_q[4*i+1] : fctl_q[4*i];
         assign inc     = fix_ev[i] & gctrl_q[FIX_BASE+i] & priv_ok;
         assign wr      = reg_wr && (reg_addr == 4'(A_FIX0 + i));
         assign fix_irq_en[i] = fctl_q[4*i+3];
         pmu_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .wr_i(wr),
            .wdata_i(reg_wdata[CNT_W-1:0]), .inc_i(inc),
            .cnt_o(fix_cnt[i]), .wrap_o(fix_wrap[i]));
      end
      for (genvar j = 0; j < NUM_GP; j++) begin : g_gp
         logic inc, wr;
         assign inc = ev_gen[j] & gctrl_q[j];
         assign wr  = reg_wr && (reg_addr == 4'(A_GP0 + j));
         pmu_cnt #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .wr_i(wr),
            .wdata_i(reg_wdata[CNT_W-1:0]), .inc_i(inc),
            .cnt_o(gp_cnt[j]), .wrap_o(gp_wrap[j]));
      end
   endgenerate

   always_comb begin
      set_vec = '0;
      set_vec[NUM_GP-1:0]         = gp_wrap;
      set_vec[FIX_BASE+:FIX_NUM]  = fix_wrap;
      set_vec[FLAG_BIT]           = flag_set;
   end

   pmu_stat #(.DW(64), .VALID(STAT_MASK), .ACK_GATED(ACK_GATED)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec),
      .ack_i(reg_wr && (reg_addr == A_ACK)), .ack_data_i(reg_wdata),
      .ctrl_live_i(|gctrl_q), .stat_o(stat_q));

   assign irq = (|stat_q[NUM_GP-1:0]) | (|(stat_q[FIX_BASE+:FIX_NUM] & fix_irq_en));

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_CTRL:  reg_rdata = gctrl_q;
         A_STAT:  reg_rdata = stat_q;
         A_FCTL:  reg_rdata = 64'(fctl_q);
         default: reg_rdata = '0;
      endcase
      for (int i = 0; i < FIX_NUM; i++)
         if (reg_addr == 4'(A_FIX0 + i)) reg_rdata = 64'(fix_cnt[i]);
      for (int j = 0; j < NUM_GP; j++)
         if (reg_addr == 4'(A_GP0 + j)) reg_rdata = 64'(gp_cnt[j]);
   end
endmodule

// File: rtl/pmu_chk.sv
`timescale 1ns/1ps
module pmu_chk #(
   parameter int NUM_GP    = 2,
   parameter int CNT_W     = 48,
   parameter bit ACK_GATED = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr,
   input logic [3:0]       reg_addr,
   input logic [63:0]      reg_wdata,
   input logic             irq,
   input logic [63:0]      stat,
   input logic [63:0]      gctrl,
   input logic [CNT_W-1:0] fix0_cnt
);
   // R6
   flag_not_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[62:0] == '0) |-> !irq);

   // R7
   ack_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 4'd2 && reg_wdata[63] && (!ACK_GATED || gctrl != '0))
      |=> !stat[63]);

   // R8
   gated_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ACK_GATED && reg_wr && reg_addr == 4'd2 && gctrl == '0) |=> $stable(stat));

   // R4
   ctrl_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (gctrl == '0 && !(reg_wr && reg_addr == 4'd4)) |=> $stable(fix0_cnt));

   // R9
   gp_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[NUM_GP-1:0] != '0) |-> irq);
endmodule

bind perf_counter_unit pmu_chk #(.NUM_GP(NUM_GP), .CNT_W(CNT_W), .ACK_GATED(ACK_GATED)) chk_i (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irq(irq), .stat(stat_q), .gctrl(gctrl_q),
   .fix0_cnt(fix_cnt[0]));

// File: tb/perf_counter_unit_tb.sv
`timescale 1ns/1ps
module perf_counter_unit_tb_top;
   localparam int NUM_GP = 2;

   typedef struct packed {
      logic [1:0]  kind;   // 0 write, 1 read, 2 count window, 3 irq check
      logic [3:0]  addr;
      logic [63:0] data;
      logic [63:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 60;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] TOP  = 64'h8000_0000_0000_0000;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 4'd0, 64'd0, 64'd0, 8'd1},                        // R1
      '{2'd1, 4'd1, 64'd0, 64'd0, 8'd1},                        // R1
      '{2'd3, 4'd0, 64'd0, 64'd0, 8'd1},                        // R1
      '{2'd1, 4'd4, 64'd0, 64'd0, 8'd1},                        // R1
      '{2'd0, 4'd3, 64'hB21, 64'd0, 8'd2},                      // R2
      '{2'd1, 4'd3, 64'd0, 64'hB21, 8'd2},                      // R2
      '{2'd0, 4'd0, 64'h7_0000_0003, 64'd0, 8'd4},
      '{2'd1, 4'd1, 64'd0, TOP, 8'd6},                          // R6
      '{2'd3, 4'd0, 64'd0, 64'd0, 8'd6},                        // R6
      '{2'd0, 4'd2, TOP, 64'd0, 8'd7},
      '{2'd1, 4'd1, 64'd0, 64'd0, 8'd7},                        // R7
      '{2'd2, 4'd0, 64'h5_001F, 64'd0, 8'd2},
      '{2'd2, 4'd0, 64'h3_011F, 64'd0, 8'd2},
      '{2'd1, 4'd4, 64'd0, 64'd5, 8'd2},                        // R2
      '{2'd1, 4'd5, 64'd0, 64'd3, 8'd2},                        // R2
      '{2'd1, 4'd6, 64'd0, 64'd8, 8'd3},                        // R3
      '{2'd1, 4'd8, 64'd0, 64'd8, 8'd3},                        // R3
      '{2'd1, 4'd9, 64'd0, 64'd8, 8'd3},                        // R3
      '{2'd0, 4'd0, 64'h1_0000_0001, 64'd0, 8'd3},
      '{2'd2, 4'd0, 64'h4_001F, 64'd0, 8'd3},
      '{2'd1, 4'd4, 64'd0, 64'd9, 8'd3},                        // R3
      '{2'd1, 4'd6, 64'd0, 64'd8, 8'd3},                        // R3
      '{2'd1, 4'd8, 64'd0, 64'd12, 8'd3},                       // R3
      '{2'd1, 4'd9, 64'd0, 64'd8, 8'd3},                        // R3
      '{2'd0, 4'd2, ONES, 64'd0, 8'd7},
      '{2'd1, 4'd1, 64'd0, 64'd0, 8'd7},                        // R7
      '{2'd0, 4'd6, 64'hFFFF_FFFF_FFFE, 64'd0, 8'd10},
      '{2'd0, 4'd0, 64'h4_0000_0000, 64'd0, 8'd5},
      '{2'd0, 4'd2, TOP, 64'd0, 8'd7},
      '{2'd2, 4'd0, 64'h1_001F, 64'd0, 8'd5},
      '{2'd1, 4'd6, 64'd0, 64'hFFFF_FFFF_FFFF, 8'd10},          // R10
      '{2'd1, 4'd1, 64'd0, 64'd0, 8'd5},                        // R5
      '{2'd2, 4'd0, 64'h1_001F, 64'd0, 8'd5},
      '{2'd1, 4'd6, 64'd0, 64'd0, 8'd5},                        // R5
      '{2'd1, 4'd1, 64'd0, 64'h4_0000_0000, 8'd5},              // R5
      '{2'd3, 4'd0, 64'd1, 64'd0, 8'd9},                        // R9
      '{2'd0, 4'd4, 64'hFFFF_FFFF_FFFF, 64'd0, 8'd5},
      '{2'd0, 4'd0, 64'h5_0000_0000, 64'd0, 8'd5},
      '{2'd2, 4'd0, 64'h1_001F, 64'd0, 8'd5},
      '{2'd1, 4'd4, 64'd0, 64'd0, 8'd5},                        // R5
      '{2'd1, 4'd6, 64'd0, 64'd1, 8'd3},                        // R3
      '{2'd1, 4'd1, 64'd0, 64'h8000_0005_0000_0000, 8'd6},      // R6
      '{2'd0, 4'd2, 64'h8000_0004_0000_0000, 64'd0, 8'd7},
      '{2'd1, 4'd1, 64'd0, 64'h1_0000_0000, 8'd7},              // R7
      '{2'd3, 4'd0, 64'd0, 64'd0, 8'd9},                        // R9
      '{2'd0, 4'd9, 64'hFFFF_FFFF_FFFF, 64'd0, 8'd5},
      '{2'd0, 4'd0, 64'h2, 64'd0, 8'd5},
      '{2'd2, 4'd0, 64'h1_001F, 64'd0, 8'd5},
      '{2'd1, 4'd9, 64'd0, 64'd0, 8'd5},                        // R5
      '{2'd1, 4'd1, 64'd0, 64'h8000_0001_0000_0002, 8'd5},      // R5
      '{2'd3, 4'd0, 64'd1, 64'd0, 8'd9},                        // R9
      '{2'd0, 4'd2, ONES, 64'd0, 8'd7},
      '{2'd3, 4'd0, 64'd0, 64'd0, 8'd9},                        // R9
      '{2'd0, 4'd8, 64'hFFFF_1234_5678_9ABC, 64'd0, 8'd10},
      '{2'd1, 4'd8, 64'd0, 64'h1234_5678_9ABC, 8'd10},          // R10
      '{2'd0, 4'd0, ONES, 64'd0, 8'd4},
      '{2'd1, 4'd0, 64'd0, 64'h7_0000_0003, 8'd4},              // R4
      '{2'd1, 4'd2, 64'd0, 64'd0, 8'd11},                       // R11
      '{2'd0, 4'd1, 64'h5, 64'd0, 8'd11},
      '{2'd1, 4'd1, 64'd0, TOP, 8'd11}                          // R11
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0;
   logic [3:0]        reg_addr = '0;
   logic [63:0]       reg_wdata = '0;
   logic [7:0]        strobes = '0;
   logic              priv_user = 1'b0;
   logic [63:0]       rdata_i, rdata_q;
   logic              irq_i, irq_q;
   int                checks = 0;
   int                errors = 0;
   bit                done = 1'b0;

   always #10 clk = ~clk;

   perf_counter_unit #(.NUM_GP(NUM_GP), .CNT_W(48), .ACK_GATED(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_i), .ev_inst(strobes[0]),
      .ev_core_clk(strobes[1]), .ev_bus_clk(strobes[2]),
      .ev_gen(strobes[3+:NUM_GP]), .priv_user(priv_user), .irq(irq_i));

   perf_counter_unit #(.NUM_GP(NUM_GP), .CNT_W(48), .ACK_GATED(1'b1)) dut_q (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(rdata_q), .ev_inst(strobes[0]),
      .ev_core_clk(strobes[1]), .ev_bus_clk(strobes[2]),
      .ev_gen(strobes[3+:NUM_GP]), .priv_user(priv_user), .irq(irq_q));

   task automatic check(input logic [63:0] act, input logic [63:0] exp, input int req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, input logic quirk, input logic [63:0] exp, input int req);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(quirk ? rdata_q : rdata_i, exp, req);
   endtask

   task automatic count(input logic [63:0] d);
      @(negedge clk);
      strobes = d[7:0]; priv_user = d[8];
      repeat (int'(d[31:16])) @(posedge clk);
      @(negedge clk);
      strobes = '0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < NV; k++) begin
         case (VECS[k].kind)
            2'd0: wr(VECS[k].addr, VECS[k].data);
            2'd1: rd(VECS[k].addr, 1'b0, VECS[k].exp, int'(VECS[k].req));
            2'd2: count(VECS[k].data);
            default: begin
               @(negedge clk);
               check(64'(irq_i), 64'(VECS[k].data[0]), int'(VECS[k].req));
            end
         endcase
      end
      wr(4'd2, TOP);
      // R8: acknowledge while control is zero
      wr(4'd0, 64'd0);
      wr(4'd2, TOP);
      rd(4'd1, 1'b0, 64'd0, 7);       // R7 ungated build clears
      rd(4'd1, 1'b1, TOP, 8);         // R8 gated build keeps the flag
      // R4: zero control stops counting
      count(64'h3_001F);
      rd(4'd6, 1'b0, 64'd1, 4);       // R4
      rd(4'd8, 1'b0, 64'h1234_5678_9ABC, 4); // R4
      wr(4'd0, 64'd1);
      wr(4'd2, TOP);
      rd(4'd1, 1'b1, 64'd0, 8);       // R8 clears once control is live
      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      rd(4'd0, 1'b0, 64'd0, 1);       // R1
      rd(4'd6, 1'b0, 64'd0, 1);       // R1
      rd(4'd3, 1'b0, 64'd0, 1);       // R1
      check(64'(irq_i), 64'd0, 1);    // R1
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule